// File: doc/BRIEF.md
# Reaction Time Measurement Controller

This block runs one reaction-time trial at a time. A start press arms it. It clears the value on show and holds a pseudo-random pause of one to ten seconds, measured in millisecond ticks. It then raises a stimulus light and counts ticks until the user presses stop. The result goes out as a binary millisecond count for a display driver, with three flags beside it: a valid reaction, a press that came too early, and a timeout. All inputs are single-cycle pulses that are already synchronous and debounced. A separate timebase supplies the millisecond tick.

The controller has four states:

- `ST_IDLE`: the value on show is kept.
- `ST_WAIT`: the random pause.
- `ST_REACT`: the stimulus is lit and the count is running.
- `ST_HOLD`: the result is on show.

Its transitions are:

- **arm**: `ST_IDLE` to `ST_WAIT`, on start.
- **early**: `ST_WAIT` to `ST_HOLD`, on stop.
- **lit**: `ST_WAIT` to `ST_REACT`, when the pause expires.
- **stopped**: `ST_REACT` to `ST_HOLD`, on stop.
- **timeout**: `ST_REACT` to `ST_HOLD`, when the count reaches its cap.
- **release**: `ST_HOLD` to `ST_IDLE`, on start or stop.
- **clear**: any state to `ST_IDLE`.

The pause length comes from a free-running 16-bit LFSR. Its value is sampled on the arming press and scaled into the allowed window.

Top module: `rxn_timer_ctrl`

## Requirements
- R1: After reset, `stim_on` is low, `react_ms` is 0 and all three flags are low.
- R2: A start press in `ST_IDLE` sets `react_ms` to 0 and lowers all flags one cycle later, with the stimulus still dark.
- R3: After arming, `stim_on` rises after N ticks, where N lies between 1000 and 9999 inclusive. The pause advances only on cycles with `ms_tick` high.
- R4: While `stim_on` is high, `react_ms` increases by exactly one on each cycle with `ms_tick` high. It holds on every other cycle, and the running value is visible.
- R5: A stop press while the stimulus is lit drops `stim_on` and sets `result_valid` one cycle later, with `react_ms` holding the ticks counted. A tick in the same cycle as stop is not counted.
- R6: A stop press during the random pause sets `too_early` and leaves `react_ms` at 0. The stimulus never lights in that trial.
- R7: If 1000 ticks pass with the stimulus lit and no stop, `react_ms` becomes 1000 in that cycle, `stim_on` falls and `timed_out` rises. The value never exceeds 1000.
- R8: In `ST_HOLD`, a start or stop press returns to `ST_IDLE` with `react_ms` and the flags unchanged. A further start press begins a new trial.
- R9: A clear press in any state leads to `stim_on` low, `react_ms` 0 and all flags low one cycle later. It takes precedence over start and stop in the same cycle, and it abandons a pause in progress.
- R10: A stop press in `ST_IDLE` changes no output.
- R11: Whenever `stim_on` is high, all three flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_pulse | input | 1 | One-cycle start button press |
| stop_pulse | input | 1 | One-cycle stop button press |
| clear_pulse | input | 1 | One-cycle clear/reset button press |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| stim_on | output | 1 | Stimulus light |
| react_ms | output | 10 | Reaction time in milliseconds (live while lit) |
| result_valid | output | 1 | A stop press captured a reaction time |
| too_early | output | 1 | Stop was pressed before the stimulus |
| timed_out | output | 1 | No stop within the capped range |

## Verification
A wrong state in this controller reaches the ports within one clock edge. A stuck pause timer shows as a stimulus that never rises or rises outside the 1000–9999 tick window. A counter that runs without ticks, or that misses a tick, shows on the next cycle as a `react_ms` step other than zero or one. A misdecoded result state raises the wrong flag on the cycle after stop or timeout. A clear or release that goes wrong leaves a stale value or flag visible one cycle after the press.

// File: rtl/rxn_pkg.sv
package rxn_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_REACT = 2'd2,
        ST_HOLD  = 2'd3
    } rxn_state_e;

    typedef enum logic [1:0] {
        RES_NONE    = 2'd0,
        RES_VALID   = 2'd1,
        RES_EARLY   = 2'd2,
        RES_TIMEOUT = 2'd3
    } rxn_result_e;

endpackage

// File: rtl/rxn_lfsr.sv
// Free-running Galois LFSR used as the pseudo-random source.
module rxn_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);

    logic [W-1:0] state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (state_q[0]) begin
            state_q <= (state_q >> 1) ^ TAPS;
        end else begin
            state_q <= state_q >> 1;
        end
    end

    assign value = state_q;

endmodule

// File: rtl/rxn_delay_map.sv
// Scales a random sample into [MIN_MS, MIN_MS + SPAN_MS) by multiply and shift.
module rxn_delay_map #(
    parameter int RND_W   = 16,
    parameter int OUT_W   = 14,
    parameter int MIN_MS  = 1000,
    parameter int SPAN_MS = 9000
) (
    input  logic [RND_W-1:0] sample,
    output logic [OUT_W-1:0] delay_ms
);

    localparam int PW = RND_W + OUT_W;

    generate
        if (SPAN_MS == 0) begin : g_fixed
            logic unused_ok;
            assign unused_ok = ^sample;
            assign delay_ms  = OUT_W'(MIN_MS);
        end else begin : g_scaled
            logic [PW-1:0] prod;
            always_comb begin
                prod     = PW'(sample) * PW'(SPAN_MS);
                delay_ms = OUT_W'(MIN_MS) + prod[RND_W +: OUT_W];
            end
        end
    endgenerate

endmodule

// File: rtl/rxn_down_timer.sv
// Loadable down counter that advances on ticks and flags its last tick.
module rxn_down_timer #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic         tick,
    output logic         expire
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && tick && cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expire = run && tick && (cnt_q == W'(1));

endmodule

// File: rtl/rxn_ms_counter.sv
// Saturating millisecond counter; sat_hit marks the increment that reaches MAX.
module rxn_ms_counter #(
    parameter int W   = 10,
    parameter int MAX = 1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         sat_hit
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && cnt_q != W'(MAX)) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign cnt     = cnt_q;
    assign sat_hit = inc && (cnt_q == W'(MAX - 1));

endmodule

// File: rtl/rxn_timer_ctrl.sv
module rxn_timer_ctrl #(
    parameter int                RND_W        = 16,
    parameter logic [RND_W-1:0]  LFSR_TAPS    = 16'hB400,
    parameter logic [RND_W-1:0]  LFSR_SEED    = 16'hACE1,
    parameter int                WAIT_MIN_MS  = 1000,
    parameter int                WAIT_MAX_MS  = 10000,
    parameter int                REACT_MAX_MS = 1000
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start_pulse,
    input  logic                                 stop_pulse,
    input  logic                                 clear_pulse,
    input  logic                                 ms_tick,
    output logic                                 stim_on,
    output logic [$clog2(REACT_MAX_MS+1)-1:0]    react_ms,
    output logic                                 result_valid,
    output logic                                 too_early,
    output logic                                 timed_out
);
    import rxn_pkg::*;

    localparam int WAIT_W    = $clog2(WAIT_MAX_MS + 1);
    localparam int MS_W      = $clog2(REACT_MAX_MS + 1);
    localparam int WAIT_SPAN = WAIT_MAX_MS - WAIT_MIN_MS;

    rxn_state_e  state_q, state_d;
    rxn_result_e result_q;
    logic        stim_q;

    logic [RND_W-1:0]  rnd;
    logic [WAIT_W-1:0] wait_len;
    logic              wait_expire;
    logic              cnt_inc, cnt_clr, sat_hit;
    logic [MS_W-1:0]   cnt;

    // transition events
    logic ev_arm, ev_early, ev_lit, ev_stopped, ev_timeout;

    always_comb begin
        ev_arm     = !clear_pulse && state_q == ST_IDLE  && start_pulse;
        ev_early   = !clear_pulse && state_q == ST_WAIT  && stop_pulse;
        ev_lit     = !clear_pulse && state_q == ST_WAIT  && !stop_pulse && wait_expire;
        ev_stopped = !clear_pulse && state_q == ST_REACT && stop_pulse;
        ev_timeout = !clear_pulse && state_q == ST_REACT && !stop_pulse && sat_hit;
    end

    rxn_lfsr #(
        .W    (RND_W),
        .TAPS (LFSR_TAPS),
        .SEED (LFSR_SEED)
    ) lfsr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd)
    );

    rxn_delay_map #(
        .RND_W   (RND_W),
        .OUT_W   (WAIT_W),
        .MIN_MS  (WAIT_MIN_MS),
        .SPAN_MS (WAIT_SPAN)
    ) map_i (
        .sample   (rnd),
        .delay_ms (wait_len)
    );

    rxn_down_timer #(
        .W (WAIT_W)
    ) wait_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ev_arm),
        .load_val (wait_len),
        .run      (state_q == ST_WAIT),
        .tick     (ms_tick),
        .expire   (wait_expire)
    );

    assign cnt_clr = clear_pulse || ev_arm;
    assign cnt_inc = state_q == ST_REACT && ms_tick && !stop_pulse && !clear_pulse;

    rxn_ms_counter #(
        .W   (MS_W),
        .MAX (REACT_MAX_MS)
    ) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .cnt     (cnt),
        .sat_hit (sat_hit)
    );

    // next state
    always_comb begin
        state_d = state_q;
        if (clear_pulse) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (start_pulse) state_d = ST_WAIT;
                ST_WAIT: begin
                    if (stop_pulse)       state_d = ST_HOLD;
                    else if (wait_expire) state_d = ST_REACT;
                end
                ST_REACT: begin
                    if (stop_pulse || sat_hit) state_d = ST_HOLD;
                end
                ST_HOLD:  if (start_pulse || stop_pulse) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stim_q   <= 1'b0;
            result_q <= RES_NONE;
        end else if (clear_pulse || ev_arm) begin
            stim_q   <= 1'b0;
            result_q <= RES_NONE;
        end else if (ev_lit) begin
            stim_q   <= 1'b1;
        end else if (ev_early) begin
            result_q <= RES_EARLY;
        end else if (ev_stopped) begin
            stim_q   <= 1'b0;
            result_q <= RES_VALID;
        end else if (ev_timeout) begin
            stim_q   <= 1'b0;
            result_q <= RES_TIMEOUT;
        end
    end

    assign stim_on      = stim_q;
    assign react_ms     = cnt;
    assign result_valid = result_q == RES_VALID;
    assign too_early    = result_q == RES_EARLY;
    assign timed_out    = result_q == RES_TIMEOUT;

endmodule

// File: rtl/rxn_timer_chk.sv
module rxn_timer_chk #(
    parameter int MS_W         = 10,
    parameter int REACT_MAX_MS = 1000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stop_pulse,
    input logic            clear_pulse,
    input logic            ms_tick,
    input logic            stim_on,
    input logic [MS_W-1:0] react_ms,
    input logic            result_valid,
    input logic            too_early,
    input logic            timed_out
);

    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (stim_on && ms_tick && !stop_pulse && !clear_pulse)
        |=> react_ms == $past(react_ms) + MS_W'(1));

    a_r4_idle_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (stim_on && !ms_tick && !clear_pulse) |=> $stable(react_ms));

    a_r5_stop_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (stim_on && stop_pulse && !clear_pulse) |=> (!stim_on && result_valid));

    a_r7_cap: assert property (@(posedge clk) disable iff (!rst_n)
        react_ms <= MS_W'(REACT_MAX_MS));

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear_pulse |=> (!stim_on && react_ms == '0 && !result_valid && !too_early && !timed_out));

    a_r11_stim_excl: assert property (@(posedge clk) disable iff (!rst_n)
        stim_on |-> !(result_valid || too_early || timed_out));

endmodule

bind rxn_timer_ctrl rxn_timer_chk #(
    .MS_W         ($clog2(REACT_MAX_MS + 1)),
    .REACT_MAX_MS (REACT_MAX_MS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_pulse   (stop_pulse),
    .clear_pulse  (clear_pulse),
    .ms_tick      (ms_tick),
    .stim_on      (stim_on),
    .react_ms     (react_ms),
    .result_valid (result_valid),
    .too_early    (too_early),
    .timed_out    (timed_out)
);

// File: tb/rxn_timer_ctrl_tb_top.sv
module rxn_timer_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_pulse = 1'b0, stop_pulse = 1'b0, clear_pulse = 1'b0, ms_tick = 1'b0;
    logic       stim_on, result_valid, too_early, timed_out;
    logic [9:0] react_ms;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    typedef struct packed {
        logic [15:0] react;
        logic        stim;
        logic        valid;
        logic        early;
        logic        tout;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    rxn_timer_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_pulse  (start_pulse),
        .stop_pulse   (stop_pulse),
        .clear_pulse  (clear_pulse),
        .ms_tick      (ms_tick),
        .stim_on      (stim_on),
        .react_ms     (react_ms),
        .result_valid (result_valid),
        .too_early    (too_early),
        .timed_out    (timed_out)
    );

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got cycle=%0d expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // driver side: push an expected output snapshot
    task automatic expect_out(input string tag, input int r, input bit s, input bit v,
                              input bit e, input bit t);
        exp_t x;
        x.react = 16'(r); x.stim = s; x.valid = v; x.early = e; x.tout = t;
        exp_q.push_back(x);
        tag_q.push_back(tag);
    endtask

    // monitor: pops and compares away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t  x;
                string t;
                x = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (16'(react_ms) != x.react || stim_on != x.stim || result_valid != x.valid ||
                    too_early != x.early || timed_out != x.tout) begin
                    fails++;
                    $display("FAIL %s: got react=%0d stim=%b v=%b e=%b t=%b expected react=%0d stim=%b v=%b e=%b t=%b",
                             t, react_ms, stim_on, result_valid, too_early, timed_out,
                             x.react, x.stim, x.valid, x.early, x.tout);
                end
            end
        end
    end

    task automatic check_range(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    // one-cycle press of any combination, ending on a negedge
    task automatic press(input bit s, input bit p, input bit c, input bit t);
        @(negedge clk);
        start_pulse = s; stop_pulse = p; clear_pulse = c; ms_tick = t;
        @(negedge clk);
        start_pulse = 0; stop_pulse = 0; clear_pulse = 0; ms_tick = 0;
    endtask

    task automatic tick(input int n);
        ms_tick = 1;
        repeat (n) @(negedge clk);
        ms_tick = 0;
    endtask

    // tick continuously until the stimulus lights; returns ticks used
    task automatic wait_stim(output int n);
        n = 0;
        ms_tick = 1;
        while (n < 12000) begin
            @(negedge clk);
            n++;
            if (stim_on) break;
        end
        ms_tick = 0;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        expect_out("R1 reset state", 0, 0, 0, 0, 0);

        press(0, 1, 0, 0);
        expect_out("R10 stop ignored in idle", 0, 0, 0, 0, 0);

        // trial 1: normal reaction
        press(1, 0, 0, 0);
        expect_out("R2 armed", 0, 0, 0, 0, 0);
        wait_stim(n);
        check_range("R3 random pause", n, 1000, 9999);
        expect_out("R3 R11 stimulus lit", 0, 1, 0, 0, 0);
        tick(37);
        expect_out("R4 R11 live count", 37, 1, 0, 0, 0);
        repeat (5) @(negedge clk);
        expect_out("R4 no tick holds", 37, 1, 0, 0, 0);
        press(0, 1, 0, 0);
        expect_out("R5 stop captures", 37, 0, 1, 0, 0);
        tick(4);
        expect_out("R5 result holds", 37, 0, 1, 0, 0);

        press(1, 0, 0, 0);
        expect_out("R8 start releases to idle", 37, 0, 1, 0, 0);
        press(1, 0, 0, 0);
        expect_out("R2 new trial clears", 0, 0, 0, 0, 0);

        // trial 2: stop together with a tick
        wait_stim(n);
        check_range("R3 random pause 2", n, 1000, 9999);
        tick(5);
        press(0, 1, 0, 1);
        expect_out("R5 stop with tick not counted", 5, 0, 1, 0, 0);
        press(0, 1, 0, 0);
        expect_out("R8 stop releases to idle", 5, 0, 1, 0, 0);

        // trial 3: early press
        press(1, 0, 0, 0);
        tick(20);
        expect_out("R3 pause not yet over", 0, 0, 0, 0, 0);
        press(0, 1, 0, 0);
        expect_out("R6 too early", 0, 0, 0, 1, 0);
        tick(200);
        expect_out("R6 no stimulus after early", 0, 0, 0, 1, 0);
        press(0, 1, 0, 0);

        // trial 4: timeout
        press(1, 0, 0, 0);
        wait_stim(n);
        check_range("R3 random pause 3", n, 1000, 9999);
        tick(999);
        expect_out("R7 just below cap", 999, 1, 0, 0, 0);
        tick(1);
        expect_out("R7 timeout", 1000, 0, 0, 0, 1);
        tick(10);
        expect_out("R7 saturated", 1000, 0, 0, 0, 1);
        press(1, 0, 0, 0);
        expect_out("R8 idle keeps timeout", 1000, 0, 0, 0, 1);

        // trial 5: clear while lit, together with start
        press(1, 0, 0, 0);
        wait_stim(n);
        tick(3);
        press(1, 0, 1, 0);
        expect_out("R9 clear over start while lit", 0, 0, 0, 0, 0);

        // trial 6: clear during pause
        press(1, 0, 0, 0);
        tick(50);
        press(0, 0, 1, 0);
        expect_out("R9 clear in pause", 0, 0, 0, 0, 0);
        tick(10200);
        expect_out("R9 pause abandoned", 0, 0, 0, 0, 0);

        @(negedge clk);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule